// File: doc/BRIEF.md
# Back-End Burst Bus Master

This block drives a simple synchronous back-end bus that has a separate 20-bit address path and a separate 16-bit data path. When a requester asks for a transfer, the master places the current burst address on the bus. It then pulls one active-low strobe low: one strobe for reads, a different one for writes. It holds that strobe for a fixed burst of 32 words. During a write it pops one word per cycle from a source FIFO and drives that word onto the bus. During a read it captures the word that the bus returns one cycle after each strobe beat and pushes it into a sink FIFO.

The master keeps its own burst address counter. The counter starts at zero after reset and advances by one at the end of every completed burst, whether that burst was a read or a write. A burst is launched only when the FIFO on the far side can cover the whole burst: the source must hold 32 words for a write, and the sink must have room for 32 words for a read. A request that asks for a read and a write in the same cycle is refused and flagged.

Requests are levels sampled while the master is idle. A requester holds its request until it sees the matching strobe, then drops it.

Top module: `be_burst_master`

## Requirements
- R1: While reset is asserted and right after it, both strobes are high (1 = inactive), `busy`, `done`, `req_err`, `src_pop` and `snk_push` are 0, and `be_addr` is 0.
- R2: A write burst starts only if `src_level` is at least 32 in the idle cycle where `start_wr` is seen. A read burst starts only if `snk_free` is at least 32. Otherwise no strobe falls, and the request waits.
- R3: A write burst holds `be_wr_n` low for exactly 32 consecutive cycles, starting the cycle after the accepting edge. In each of those cycles `src_pop` is 1 and `be_wdata` equals `src_data`.
- R4: A read burst holds `be_rd_n` low for exactly 32 consecutive cycles. `snk_push` is 1 in each of the 32 cycles that follow a strobe-low cycle, and `snk_data` carries the `be_rdata` value present in that following cycle.
- R5: `be_rd_n` and `be_wr_n` are never low in the same cycle.
- R6: If `start_rd` and `start_wr` are both 1 in an idle cycle, `req_err` is 1 for one cycle on the next cycle, and neither strobe falls.
- R7: `done` is a single-cycle pulse. For a write it comes in the cycle after the last strobe-low cycle. For a read it comes one cycle later, after the 32nd word has been pushed. Both strobes are high while `done` is 1.
- R8: `be_addr` takes its new value, the old value plus one, in the `done` cycle of each burst.
- R9: `be_addr` does not change in any cycle other than a `done` cycle, so it is constant for the whole burst.
- R10: A request that arrives while a burst is in progress is ignored: it does not disturb the running burst and no other strobe falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_wr | input | 1 | Write burst request (level) |
| start_rd | input | 1 | Read burst request (level) |
| src_level | input | 6 | Words held in the source FIFO |
| snk_free | input | 6 | Free word slots in the sink FIFO |
| src_data | input | 16 | Head word of the source FIFO |
| src_pop | output | 1 | Pop the source FIFO head |
| snk_push | output | 1 | Push `snk_data` into the sink FIFO |
| snk_data | output | 16 | Word for the sink FIFO |
| be_addr | output | 20 | Back-end burst address |
| be_rd_n | output | 1 | Active-low read strobe |
| be_wr_n | output | 1 | Active-low write strobe |
| be_wdata | output | 16 | Back-end write data |
| be_rdata | input | 16 | Back-end read data |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | Burst completion pulse |
| req_err | output | 1 | Conflicting read and write request |

## Verification
On every cycle the assertions check:
- the FIFO-level gating of each strobe fall;
- that a strobe rises only after the final beat of the burst counter;
- that a sink push always follows a read-strobe cycle;
- that an error cycle and the done cycle carry no strobe;
- that the burst address steps by one only in a done cycle.

Only the bench scenarios can show the rest:
- the exact 32-beat length;
- the word-by-word data order on both paths;
- the relative position of the done pulse for reads and writes;
- that a request landing mid-burst leaves the burst untouched.

// File: rtl/be_pkg.sv
`timescale 1ns/1ps
package be_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_TAIL = 2'd3
  } be_state_e;
endpackage

// File: rtl/be_beat_ctr.sv
`timescale 1ns/1ps
// Counts the beats of one burst; wraps to zero after the final beat.
module be_beat_ctr #(
  parameter int BURST = 32,
  localparam int BW = $clog2(BURST)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic last
);
  logic [BW-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == BW'(BURST - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      cnt_d = last ? '0 : cnt_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/be_addr_ctr.sv
`timescale 1ns/1ps
// Burst address register; advances by one per completed burst.
module be_addr_ctr #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (inc) addr_d = addr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_d;
  end
endmodule

// File: rtl/be_master_fsm.sv
`timescale 1ns/1ps
module be_master_fsm
  import be_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_wr,
  input  logic      start_rd,
  input  logic      wr_ok,
  input  logic      rd_ok,
  input  logic      last,
  output be_state_e state,
  output logic      done_q,
  output logic      err_q,
  output logic      inc
);
  be_state_e nxt;
  logic      done_d, err_d;

  always_comb begin
    nxt    = state;
    done_d = 1'b0;
    err_d  = 1'b0;
    inc    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start_wr && start_rd)  err_d = 1'b1;
        else if (start_wr && wr_ok) nxt = ST_WR;
        else if (start_rd && rd_ok) nxt = ST_RD;
      end
      ST_WR: begin
        if (last) begin
          nxt    = ST_IDLE;
          done_d = 1'b1;
          inc    = 1'b1;
        end
      end
      ST_RD: begin
        if (last) nxt = ST_TAIL;
      end
      ST_TAIL: begin
        nxt    = ST_IDLE;
        done_d = 1'b1;
        inc    = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      state  <= nxt;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  // R3/R4: a burst leaves its data state only on the final counted beat
  assert_burst_end_on_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_WR && state != ST_WR) |-> $past(last));
  assert_read_end_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_RD && state != ST_RD) |-> $past(last));
endmodule

// File: rtl/be_burst_master.sv
`timescale 1ns/1ps
module be_burst_master
  import be_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int BURST      = 32,
  parameter int FIFO_DEPTH = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [LVL_W-1:0]  src_level,
  input  logic [LVL_W-1:0]  snk_free,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_pop,
  output logic              snk_push,
  output logic [DATA_W-1:0] snk_data,
  output logic [ADDR_W-1:0] be_addr,
  output logic              be_rd_n,
  output logic              be_wr_n,
  output logic [DATA_W-1:0] be_wdata,
  input  logic [DATA_W-1:0] be_rdata,
  output logic              busy,
  output logic              done,
  output logic              req_err
);
  be_state_e state;
  logic      last, inc, wr_ok, rd_ok, beat_en, rd_dly_q;

  assign wr_ok   = (src_level >= LVL_W'(BURST));
  assign rd_ok   = (snk_free  >= LVL_W'(BURST));
  assign beat_en = (state == ST_WR) || (state == ST_RD);

  be_master_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .last(last), .state(state),
    .done_q(done), .err_q(req_err), .inc(inc)
  );

  be_beat_ctr #(.BURST(BURST)) u_beat (
    .clk(clk), .rst_n(rst_n), .en(beat_en), .last(last)
  );

  be_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .inc(inc), .addr(be_addr)
  );

  // read data returns one cycle after each strobe beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_dly_q <= 1'b0;
    else        rd_dly_q <= (state == ST_RD);
  end

  assign be_wr_n  = (state != ST_WR);
  assign be_rd_n  = (state != ST_RD);
  assign src_pop  = (state == ST_WR);
  assign be_wdata = (state == ST_WR) ? src_data : '0;
  assign snk_push = rd_dly_q;
  assign snk_data = be_rdata;
  assign busy     = (state != ST_IDLE);

  assert_wr_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(be_wr_n) |-> ($past(src_level) >= LVL_W'(BURST)));
  assert_rd_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(be_rd_n) |-> ($past(snk_free) >= LVL_W'(BURST)));
  assert_push_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    snk_push |-> $past(!be_rd_n));
  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(be_rd_n) |-> $past(be_wr_n));
  assert_err_no_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (be_rd_n && be_wr_n));
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (be_rd_n && be_wr_n && !snk_push));
  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (be_addr == $past(be_addr) + ADDR_W'(1)));
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(be_addr));
endmodule

// File: tb/test_be_burst_master.sv
`timescale 1ns/1ps
module test_be_burst_master;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int LW = 6;

  // vector: bit7 kind (0 write, 1 read), bits6:1 FIFO level, bit0 burst expected
  localparam logic [7:0] VEC [7] = '{
    {1'b0, 6'd32, 1'b1},
    {1'b0, 6'd31, 1'b0},
    {1'b0, 6'd63, 1'b1},
    {1'b1, 6'd32, 1'b1},
    {1'b1, 6'd0,  1'b0},
    {1'b1, 6'd40, 1'b1},
    {1'b0, 6'd5,  1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start_wr, start_rd;
  logic [LW-1:0] src_level, snk_free;
  logic [DW-1:0] src_data, snk_data, be_wdata, be_rdata;
  logic src_pop, snk_push, be_rd_n, be_wr_n, busy, done, req_err;
  logic [AW-1:0] be_addr;
  logic [15:0] popcnt, rcnt;
  int checks = 0;
  int errors = 0;
  logic [AW-1:0] exp_addr;

  always #4 clk = ~clk;

  be_burst_master i_be_burst_master (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
    .src_level(src_level), .snk_free(snk_free), .src_data(src_data),
    .src_pop(src_pop), .snk_push(snk_push), .snk_data(snk_data),
    .be_addr(be_addr), .be_rd_n(be_rd_n), .be_wr_n(be_wr_n),
    .be_wdata(be_wdata), .be_rdata(be_rdata), .busy(busy), .done(done),
    .req_err(req_err)
  );

  // source FIFO head and back-end read data models
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      popcnt <= '0;
      rcnt   <= '0;
    end else begin
      if (src_pop)  popcnt <= popcnt + 16'd1;
      if (!be_rd_n) rcnt   <= rcnt + 16'd1;
    end
  end
  assign src_data = 16'h5000 + popcnt;
  assign be_rdata = 16'hA000 + rcnt;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run(input bit kind, input int level, input bit go, input bit poke);
    int lows = 0, pushes = 0, donei = -1, dones = 0, bad = 0, other = 0, gap = 0;
    logic [15:0] pbase, rbase;
    if (kind) begin snk_free = LW'(level); src_level = '0; end
    else      begin src_level = LW'(level); snk_free = '0; end
    pbase = popcnt;
    rbase = rcnt;
    if (kind) start_rd = 1'b1; else start_wr = 1'b1;
    if (!go) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (!(be_wr_n && be_rd_n && !busy)) bad++;
      end
      chk(bad == 0, "R2 no burst below level", bad, 0);
      start_rd = 1'b0; start_wr = 1'b0;
      @(negedge clk);
      return;
    end
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 0) begin start_rd = 1'b0; start_wr = 1'b0; end
      if (poke && i == 10) begin if (kind) start_wr = 1'b1; else start_rd = 1'b1; end
      if (poke && i == 12) begin start_wr = 1'b0; start_rd = 1'b0; end
      if ((kind ? !be_rd_n : !be_wr_n)) begin
        if (i != lows) gap++;
        if (!kind && !(src_pop && be_wdata == 16'h5000 + pbase + 16'(lows))) bad++;
        if (be_addr != exp_addr) bad++;
        lows++;
      end
      if ((kind ? !be_wr_n : !be_rd_n)) other++;
      if (snk_push) begin
        if (i != pushes + 1) gap++;
        if (snk_data != 16'hA000 + rbase + 16'(pushes) + 16'd1) bad++;
        pushes++;
      end
      if (done) begin
        dones++;
        donei = i;
        if (be_addr != exp_addr + AW'(1)) bad++;
        if (!(be_rd_n && be_wr_n)) bad++;
      end
    end
    chk(lows == 32, kind ? "R4 read strobe length" : "R3 write strobe length", lows, 32);
    chk(gap == 0, "R3/R4 beats consecutive", gap, 0);
    chk(pushes == (kind ? 32 : 0), "R4 push count", pushes, kind ? 32 : 0);
    chk(bad == 0, "R3/R4/R9 data and address", bad, 0);
    chk(dones == 1 && donei == (kind ? 33 : 32), "R7 done position", donei, kind ? 33 : 32);
    chk(other == 0, poke ? "R10 request during burst ignored" : "R5 other strobe idle", other, 0);
    exp_addr = exp_addr + AW'(1);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_wr = 1'b0; start_rd = 1'b0;
    src_level = '0; snk_free = '0;
    exp_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(be_rd_n && be_wr_n && !busy && !done && !req_err && !src_pop && !snk_push,
        "R1 outputs in reset", 0, 1);
    chk(be_addr == '0, "R1 address in reset", be_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(be_rd_n && be_wr_n && !busy && be_addr == '0, "R1 after release", be_addr, 0);

    for (int v = 0; v < 7; v++) begin
      run(VEC[v][7], int'(VEC[v][6:1]), VEC[v][0], 1'b0);
    end

    // R6: conflicting request
    src_level = 6'd40; snk_free = 6'd40;
    start_wr = 1'b1; start_rd = 1'b1;
    @(negedge clk);
    start_wr = 1'b0; start_rd = 1'b0;
    chk(req_err == 1'b1, "R6 error pulse", req_err, 1);
    chk(be_rd_n && be_wr_n && !busy, "R6 no burst on conflict", busy, 0);
    @(negedge clk);
    chk(req_err == 1'b0 && be_rd_n && be_wr_n, "R6 error one cycle", req_err, 0);

    // R10: requests that arrive mid-burst
    run(1'b0, 32, 1'b1, 1'b1);
    run(1'b1, 32, 1'b1, 1'b1);
    @(negedge clk);
    chk(be_rd_n && be_wr_n && !busy, "R10 no late burst", busy, 0);

    // R8: address counts completed bursts
    chk(be_addr == AW'(6), "R8 final burst address", be_addr, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule